// File: doc/BRIEF.md
# Flash Block RAM-Overlay Address Remapper

This block sits on the CPU address path next to the on-chip flash and RAM. It lets a 1 KB window of on-chip RAM stand in for one of four 1 KB flash blocks at the top of the flash space. Code can then rehearse real-time flash updates in RAM, confirm the data, and afterwards copy it into the real flash block. While the overlay is on, the same RAM cells answer at their own address window and at the chosen flash block address.

A small control register holds an overlay enable and a 2-bit block select. Software writes it through a synchronous write port. From the 32-bit address the block produces a flash select, a RAM select and a 10-bit RAM offset. The block also gates the program and erase requests that come from the flash control bits. While the overlay is on, no flash block can enter program or erase mode.

Top module: `flash_overlay_remap`

## Requirements
- R1: After reset the control register is all zeros, so the overlay is off and a flash address such as 0x0003F000 asserts flash_sel only.
- R2: An address in 0xFFFFD800..0xFFFFDBFF asserts ram_sel with flash_sel low and ram_off = addr[9:0]. This holds whether the overlay is on or off.
- R3: With the overlay on and select value s (0..3), an address in the 1 KB block starting at 0x0003F000 + s*0x400 asserts ram_sel with flash_sel low and ram_off = addr[9:0]. Select 0 chooses 0x3F000, 1 chooses 0x3F400, 2 chooses 0x3F800 and 3 chooses 0x3FC00.
- R4: With the overlay on, a flash address (0x00000000..0x0003FFFF) outside the selected block asserts flash_sel only.
- R5: With the overlay off, every flash address asserts flash_sel only, including addresses in the four candidate blocks.
- R6: An address outside both the flash range and the RAM window asserts neither select.
- R7: While the overlay is on, prog_mode and erase_mode stay low for every combination of the four request inputs and every select value.
- R8: While the overlay is off, prog_mode = p1_req | p2_req and erase_mode = e1_req | e2_req.
- R9: The control register loads cfg_en_wr (enable) and cfg_sel_wr (select) on a rising clock edge where cfg_we is high. With cfg_we low it holds its value, whatever is on the data inputs.
- R10: flash_sel and ram_sel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_en_wr | input | 1 | Overlay enable value to write |
| cfg_sel_wr | input | 2 | Block select value to write |
| addr | input | 32 | CPU access address |
| flash_sel | output | 1 | Access goes to the flash array |
| ram_sel | output | 1 | Access goes to the on-chip RAM |
| ram_off | output | 10 | Offset into the 1 KB RAM window |
| p1_req | input | 1 | Program request, control register 1 |
| e1_req | input | 1 | Erase request, control register 1 |
| p2_req | input | 1 | Program request, control register 2 |
| e2_req | input | 1 | Erase request, control register 2 |
| prog_mode | output | 1 | Program mode granted |
| erase_mode | output | 1 | Erase mode granted |

## Verification
The decode has no pipeline stage, so a wrong enable or select bit in the control register shows on the very next access into a candidate block. The access goes to RAM where flash was expected, or the reverse. A stuck enable bit also shows at once on the mode outputs: program and erase are either blocked when they should be granted or granted while the overlay is on. Because of this, every block select value is written and then probed at both of its edge addresses and in its neighbouring block.

// File: rtl/flash_overlay_remap.sv
module flash_overlay_remap #(
  parameter int ADDR_W = 32,
  parameter int BLK_W = 10,
  parameter int SEL_W = 2,
  parameter logic [ADDR_W-1:0] FLASH_END = 32'h0003_FFFF,
  parameter logic [ADDR_W-1:0] OVL_BASE = 32'h0003_F000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'hFFFF_D800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en_wr,
  input  logic [SEL_W-1:0]  cfg_sel_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              flash_sel,
  output logic              ram_sel,
  output logic [BLK_W-1:0]  ram_off,
  input  logic              p1_req,
  input  logic              e1_req,
  input  logic              p2_req,
  input  logic              e2_req,
  output logic              prog_mode,
  output logic              erase_mode
);
  localparam int TAG_W = ADDR_W - BLK_W;

  logic             ovl_en;
  logic [SEL_W-1:0] ovl_sel;
  logic [ADDR_W-1:0] ovl_base;
  logic flash_hit, ram_hit, ovl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_en  <= 1'b0;
      ovl_sel <= '0;
    end else if (cfg_we) begin
      ovl_en  <= cfg_en_wr;
      ovl_sel <= cfg_sel_wr;
    end
  end

  assign ovl_base  = OVL_BASE + ({{(ADDR_W-SEL_W){1'b0}}, ovl_sel} << BLK_W);
  assign flash_hit = addr <= FLASH_END;
  assign ram_hit   = addr[ADDR_W-1:BLK_W] == RAM_BASE[ADDR_W-1:BLK_W];
  assign ovl_hit   = ovl_en && (addr[ADDR_W-1:BLK_W] == ovl_base[ADDR_W-1:BLK_W]);

  assign flash_sel = flash_hit && !ovl_hit;
  assign ram_sel   = ram_hit || ovl_hit;
  assign ram_off   = addr[BLK_W-1:0];

  // emulation protection
  assign prog_mode  = (p1_req || p2_req) && !ovl_en;
  assign erase_mode = (e1_req || e2_req) && !ovl_en;

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = '0;
endmodule

module flash_overlay_remap_chk #(
  parameter int ADDR_W = 32,
  parameter int BLK_W = 10,
  parameter int SEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] addr,
  input logic              flash_sel,
  input logic              ram_sel,
  input logic [BLK_W-1:0]  ram_off,
  input logic              prog_mode,
  input logic              erase_mode,
  input logic              ovl_en,
  input logic [SEL_W-1:0]  ovl_sel
);
  a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_sel && ram_sel));

  a_r7_protect: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_en |-> (!prog_mode && !erase_mode));

  a_r2_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:BLK_W] == 22'h3FFFF6) |-> (ram_sel && !flash_sel && ram_off == addr[BLK_W-1:0]));

  a_r6_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 32'h0003_FFFF && addr[ADDR_W-1:BLK_W] != 22'h3FFFF6) |-> (!ram_sel && !flash_sel));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable({ovl_en, ovl_sel}));

  a_r5_off_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovl_en && addr <= 32'h0003_FFFF) |-> (flash_sel && !ram_sel));
endmodule

bind flash_overlay_remap flash_overlay_remap_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr(addr),
  .flash_sel(flash_sel), .ram_sel(ram_sel), .ram_off(ram_off),
  .prog_mode(prog_mode), .erase_mode(erase_mode),
  .ovl_en(ovl_en), .ovl_sel(ovl_sel)
);

// File: tb/flash_overlay_remap_test.sv
module flash_overlay_remap_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en_wr = 1'b0;
  logic [1:0] cfg_sel_wr = '0;
  logic [31:0] addr = '0;
  logic p1_req = 0, e1_req = 0, p2_req = 0, e2_req = 0;
  logic flash_sel, ram_sel, prog_mode, erase_mode;
  logic [9:0] ram_off;

  typedef struct packed {
    logic fs; logic rs; logic [9:0] off; logic pm; logic em;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  logic m_en = 1'b0;
  logic [1:0] m_sel = '0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_overlay_remap uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en_wr(cfg_en_wr),
    .cfg_sel_wr(cfg_sel_wr), .addr(addr), .flash_sel(flash_sel),
    .ram_sel(ram_sel), .ram_off(ram_off), .p1_req(p1_req), .e1_req(e1_req),
    .p2_req(p2_req), .e2_req(e2_req), .prog_mode(prog_mode), .erase_mode(erase_mode)
  );

  function automatic exp_t model(input logic [31:0] a, input logic [3:0] rq);
    exp_t e;
    logic [31:0] blk;
    blk = 32'h0003_F000 + 32'h400 * {30'd0, m_sel};
    e.off = a[9:0];
    e.rs = (a >= 32'hFFFF_D800 && a <= 32'hFFFF_DBFF) ||
           (m_en && a >= blk && a <= blk + 32'h3FF);
    e.fs = (a <= 32'h0003_FFFF) && !e.rs;
    e.pm = !m_en && (rq[3] || rq[1]);
    e.em = !m_en && (rq[2] || rq[0]);
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [3:0] rq, input string tag);
    @(posedge clk); #1;
    addr = a;
    {p1_req, e1_req, p2_req, e2_req} = rq;
    exp_q.push_back(model(a, rq));
    tag_q.push_back(tag);
  endtask

  task automatic cfg(input logic en, input logic [1:0] sel, input logic we);
    @(posedge clk); #1;
    cfg_we = we; cfg_en_wr = en; cfg_sel_wr = sel;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (we) begin m_en = en; m_sel = sel; end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = '{flash_sel, ram_sel, ram_off, prog_mode, erase_mode};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s addr=%h got fs=%b rs=%b off=%h pm=%b em=%b exp fs=%b rs=%b off=%h pm=%b em=%b",
                 t, addr, g.fs, g.rs, g.off, g.pm, g.em, e.fs, e.rs, e.off, e.pm, e.em);
      end
    end
  end

  initial begin
    drive(32'h0003_F000, 4'b0000, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    drive(32'h0003_F000, 4'b0000, "R1 after reset");
    drive(32'h0003_FC55, 4'b0000, "R5 off candidate");
    drive(32'hFFFF_D800, 4'b0000, "R2 window low");
    drive(32'hFFFF_DBFF, 4'b0000, "R2 window high");
    drive(32'hFFFF_DC00, 4'b0000, "R6 above window");
    drive(32'hFFFF_D7FF, 4'b0000, "R6 below window");
    drive(32'h0004_0000, 4'b0000, "R6 past flash");
    drive(32'h0000_1234, 4'b1010, "R8 program");
    drive(32'h0000_1234, 4'b0101, "R8 erase");
    drive(32'h0000_1234, 4'b0010, "R8 p2 only");
    for (int s = 0; s < 4; s++) begin
      logic [31:0] b;
      b = 32'h0003_F000 + 32'h400 * s;
      cfg(1'b1, s[1:0], 1'b1);
      drive(b, 4'b0000, "R3 block start");
      drive(b + 32'h3FF, 4'b0000, "R3 block end");
      drive(b + 32'h123, 4'b1111, "R7 all requests");
      drive(b - 32'h1, 4'b0000, "R4 below block");
      drive(32'h0000_0800, 4'b1000, "R7 p1 blocked");
      drive(32'hFFFF_D9AB, 4'b0100, "R2 window while on");
      if (s < 3) drive(b + 32'h400, 4'b0000, "R4 above block");
    end
    drive(32'h0003_FFFF, 4'b0000, "R3 flash top");
    cfg(1'b0, 2'b01, 1'b0);
    drive(32'h0003_FC10, 4'b0001, "R9 write ignored");
    cfg(1'b0, 2'b11, 1'b1);
    drive(32'h0003_FC10, 4'b0001, "R5 released");
    drive(32'h0003_F000, 4'b1111, "R8 released modes");
    cfg(1'b1, 2'b10, 1'b1);
    drive(32'h0003_F800, 4'b1111, "R9 write taken");
    drive(32'hFFFF_D800, 4'b0000, "R10 window");
    @(posedge clk); @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule